// File: doc/BRIEF.md
# Gate-Composed Multiply-Accumulate Unit

This block sums a stream of unsigned products. When the strobe `in_vld` is high, the two 4-bit operands are multiplied into an 8-bit product. That product is added to the running total, and the new total is stored on the next rising clock edge. Software or a sequencer drives one operand pair per cycle. It reads the running total from `acc` at any time and resets it with `rst`.

None of the arithmetic or storage uses behavioural operators. The partial products come from Peres cells. Each row of partial products is summed by a ripple chain made of Peres half-adder cells and double-Peres full-adder cells. The same chain forms the accumulating adder. Each storage bit has three stages before its flop: a Fredkin cell as the load mux, a second Fredkin cell as the clear, and a pair of Feynman cells that invert the bit twice. Every cell has constant inputs tied off, and its spare outputs are left as garbage. When the total passes 255 it wraps, and a sticky flag records that a carry left the 8-bit adder.

Top module: `rev_mac`

## Requirements
- R1: With `rst` high at a rising edge, `acc` reads 0 and `ovf` reads 0 after that edge.
- R2: With `rst` low and `in_vld` high at a rising edge, `acc` after that edge equals its previous value plus `opa*opb`, where both operands are unsigned.
- R3: With `rst` low and `in_vld` low at a rising edge, `acc` and `ovf` keep their values across that edge whatever the operands are.
- R4: The stored total is the true sum taken modulo 256, so only its low 8 bits are kept.
- R5: When an accepted update makes the unwrapped sum exceed 255, `ovf` reads 1 after that edge.
- R6: Once set, `ovf` stays at 1 through further updates and idle cycles until `rst` clears it.
- R7: `rst` takes priority over `in_vld`: a cycle with both high clears the state and adds nothing.
- R8: The product is exact for every one of the 256 operand pairs, up to 15*15 = 225.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of total and flag |
| in_vld | input | 1 | Accept the operand pair this cycle |
| opa | input | 4 | Unsigned multiplicand |
| opb | input | 4 | Unsigned multiplier |
| acc | output | 8 | Running total, modulo 256 |
| ovf | output | 1 | Sticky flag: a carry left the 8-bit adder |

## Verification
A fault in one partial-product cell or adder cell gives a wrong `acc` on the edge that follows the first operand pair that exercises it. The exhaustive sweep of single products from a cleared total finds such a fault within one cycle of that pair. A storage bit that fails to hold or fails to load shows up as a change of `acc` during idle cycles, or as a missing update during accepted cycles. The accumulation sequences catch both, and they also cover wrap, the flag being set and the flag being kept.

// File: rtl/rev_mac_pkg.sv
package rev_mac_pkg;
    localparam int OPW  = 4;
    localparam int ACCW = 2 * OPW;

    typedef logic [OPW-1:0]  opnd_t;
    typedef logic [ACCW-1:0] acc_t;

    typedef struct packed {
        logic ovf;
        acc_t sum;
    } mac_state_t;

    localparam int STW = $bits(mac_state_t);
endpackage

// File: rtl/rg_cells.sv
// Modelled reversible cells. P outputs copy the control input and are garbage in most uses.
module rg_feynman (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;
endmodule

module rg_peres (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ^ b;
    assign r = (a & b) ^ c;
endmodule

module rg_dperes (
    input  logic a,
    input  logic b,
    input  logic c,
    input  logic d,
    output logic p,
    output logic q,
    output logic r,
    output logic s
);
    assign p = a;
    assign q = a ^ b;
    assign r = a ^ b ^ d;
    assign s = ((a ^ b) & d) ^ (a & b) ^ c;
endmodule

module rg_fredkin (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = a ? c : b;
    assign r = a ? b : c;
endmodule

// File: rtl/rg_ripple.sv
// Ripple adder: Peres half adder at bit 0, double-Peres full adders above.
module rg_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:1]   cy;
    logic [W-1:0] gp_unused;
    logic [W-1:0] gq_unused;

    for (genvar j = 0; j < W; j++) begin : g_bit
        if (j == 0) begin : g_half
            rg_peres u_ha (
                .a(a[0]), .b(b[0]), .c(1'b0),
                .p(gp_unused[0]), .q(s[0]), .r(cy[1])
            );
            assign gq_unused[0] = 1'b0;
        end else begin : g_full
            rg_dperes u_fa (
                .a(a[j]), .b(b[j]), .c(1'b0), .d(cy[j]),
                .p(gp_unused[j]), .q(gq_unused[j]), .r(s[j]), .s(cy[j+1])
            );
        end
    end

    assign co = cy[W];
endmodule

// File: rtl/rg_mult.sv
// Array multiplier: Peres partial products, one ripple row per multiplier bit.
module rg_mult
    import rev_mac_pkg::*;
(
    input  opnd_t x,
    input  opnd_t y,
    output acc_t  prod
);
    logic [OPW-1:0] pp     [OPW];
    logic [OPW-1:0] pp_unused_p [OPW];
    logic [OPW-1:0] pp_unused_q [OPW];
    logic [OPW-1:0] run    [OPW];
    logic [OPW-1:0] rs     [1:OPW-1];
    logic           rc     [1:OPW-1];

    for (genvar i = 0; i < OPW; i++) begin : g_row
        for (genvar j = 0; j < OPW; j++) begin : g_col
            rg_peres u_pp (
                .a(x[j]), .b(y[i]), .c(1'b0),
                .p(pp_unused_p[i][j]), .q(pp_unused_q[i][j]), .r(pp[i][j])
            );
        end
        if (i == 0) begin : g_first
            assign prod[0] = pp[0][0];
            assign run[0]  = {1'b0, pp[0][OPW-1:1]};
        end else begin : g_add
            rg_ripple #(.W(OPW)) u_row (
                .a(run[i-1]), .b(pp[i]), .s(rs[i]), .co(rc[i])
            );
            assign prod[i] = rs[i][0];
            assign run[i]  = {rc[i], rs[i][OPW-1:1]};
        end
    end

    assign prod[ACCW-1:OPW] = run[OPW-1];
endmodule

// File: rtl/rg_store.sv
// Register: Fredkin load mux, Fredkin clear, double Feynman restore, edge flop.
module rg_store #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;
    logic [W-1:0] cleared;
    logic [W-1:0] inv;
    logic [W-1:0] nxt;
    logic [W-1:0] g1_unused, g2_unused, g3_unused, g4_unused, g5_unused, g6_unused;

    for (genvar i = 0; i < W; i++) begin : g_bit
        rg_fredkin u_load (
            .a(en), .b(d[i]), .c(q[i]),
            .p(g1_unused[i]), .q(g2_unused[i]), .r(held[i])
        );
        rg_fredkin u_clr (
            .a(rst), .b(1'b0), .c(held[i]),
            .p(g3_unused[i]), .q(g4_unused[i]), .r(cleared[i])
        );
        rg_feynman u_inv (
            .a(cleared[i]), .b(1'b1), .p(g5_unused[i]), .q(inv[i])
        );
        rg_feynman u_rest (
            .a(inv[i]), .b(1'b1), .p(g6_unused[i]), .q(nxt[i])
        );
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/rev_mac.sv
module rev_mac
    import rev_mac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_vld,
    input  logic [3:0] opa,
    input  logic [3:0] opb,
    output logic [7:0] acc,
    output logic       ovf
);
    acc_t       prod;
    acc_t       sum;
    logic       cout;
    logic       or_x, or_a;
    logic       gp_unused, gf_unused;
    mac_state_t st_d, st_q;

    rg_mult u_mult (.x(opa), .y(opb), .prod(prod));

    rg_ripple #(.W(ACCW)) u_add (
        .a(st_q.sum), .b(prod), .s(sum), .co(cout)
    );

    // Sticky flag: a|b built as (a^b) ^ (a&b)
    rg_peres u_or (
        .a(st_q.ovf), .b(cout), .c(1'b0),
        .p(gp_unused), .q(or_x), .r(or_a)
    );
    rg_feynman u_orf (.a(or_a), .b(or_x), .p(gf_unused), .q(st_d.ovf));

    assign st_d.sum = sum;

    rg_store #(.W(STW)) u_reg (
        .clk(clk), .rst(rst), .en(in_vld), .d(st_d), .q(st_q)
    );

    assign acc = st_q.sum;
    assign ovf = st_q.ovf;

    logic [ACCW:0] wide_chk;
    assign wide_chk = {1'b0, acc} + (ACCW+1)'(opa) * (ACCW+1)'(opb);

    // R1 R7
    clear_chk: assert property (@(posedge clk) rst |=> (acc == '0 && !ovf));
    // R2 R4
    update_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> acc == $past(wide_chk[ACCW-1:0]));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(acc) && $stable(ovf)));
    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && wide_chk[ACCW]) |=> ovf);
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    // R8
    prod_chk: assert property (@(posedge clk) disable iff (rst)
        prod == acc_t'(opa) * acc_t'(opb));
endmodule

// File: tb/test_rev_mac.sv
module test_rev_mac;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [7:0] acc;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m_acc = '0;
    logic       m_ovf = 1'b0;

    always #2 clk = ~clk;

    rev_mac i_rev_mac (
        .clk(clk), .rst(rst), .in_vld(in_vld),
        .opa(opa), .opb(opb), .acc(acc), .ovf(ovf)
    );

    task automatic check(input string tag);
        checks++;
        if (acc !== m_acc || ovf !== m_ovf) begin
            errors++;
            $display("FAIL %s acc=%0d ovf=%0b expected acc=%0d ovf=%0b",
                     tag, acc, ovf, m_acc, m_ovf);
        end
    endtask

    task automatic cycle(input logic r, input logic v, input logic [3:0] a,
                         input logic [3:0] b, input string tag);
        logic [8:0] s;
        @(negedge clk);
        rst = r; in_vld = v; opa = a; opb = b;
        @(posedge clk);
        #1;
        if (r) begin
            m_acc = '0; m_ovf = 1'b0;
        end else if (v) begin
            s = {1'b0, m_acc} + 9'(a) * 9'(b);
            m_ovf = m_ovf | s[8];
            m_acc = s[7:0];
        end
        check(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycle(1, 0, 0, 0, "R1 reset");
        // R8 R2: every operand pair from a cleared total
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                cycle(1, 0, 0, 0, "R1 clear");
                cycle(0, 1, 4'(a), 4'(b), "R8 product");
            end
        end
        // R3: idle with changing operands
        cycle(0, 1, 7, 9, "R2 add");
        for (int k = 0; k < 8; k++) cycle(0, 0, 4'(k + 5), 4'(15 - k), "R3 hold");
        // R4 R5: wrap sets the flag
        cycle(1, 0, 0, 0, "R1 clear");
        cycle(0, 1, 15, 15, "R2 add 225");
        cycle(0, 1, 5, 6, "R4 wrap 255");
        cycle(0, 1, 1, 1, "R5 carry out");
        // R6: flag kept across adds and idles
        cycle(0, 1, 2, 3, "R6 sticky add");
        cycle(0, 0, 15, 15, "R6 sticky idle");
        cycle(0, 1, 0, 9, "R6 zero product");
        // R7: clear beats strobe
        cycle(1, 1, 15, 15, "R7 priority");
        cycle(0, 0, 3, 3, "R7 after clear");
        // R2 R4 R5 R6: long random accumulation runs
        for (int run = 0; run < 20; run++) begin
            cycle(1, 0, 0, 0, "R1 clear");
            for (int k = 0; k < 40; k++)
                cycle(0, 1'($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom),
                      "R2 R4 R5 accumulate");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule